// File: doc/BRIEF.md
# Partial-Address Load/Store Overlap Matrix

This block looks at up to four pending loads and four pending stores and reports, for every ordered pair of them, whether the two accesses might touch a common byte. It does this without full-width address comparators. Each operation is reduced to a short key with three parts. The first is an exact copy of address bits 11:4, called the band. The second is a 16-bit byte-lane mask, built from the low four address bits and the access size. The third is a 5-bit folded tag taken from the upper address bits. Two operations are reported as possibly overlapping only when their bands are equal, their tags are equal and their lane masks share a set bit. There is one exception. An access that runs past the end of its 16-byte row is treated as overlapping every other valid operation, so a carry into bit 4 can never hide a real conflict.

The result only advises the issue logic about parallelism. A reported hit may be a false positive. A real byte overlap between addresses inside the 4MiB window is always reported. The matrix is registered. Inputs presented in one cycle appear in the matrix after the next rising clock edge. The inputs are sampled on every cycle, with no handshake and no back-pressure: a slot whose valid bit is low simply takes no part in any pair.

Top module: `lsq_overlap_matrix`

## Requirements
- R1: The matrix is registered. Inputs present before a rising edge are reflected in `hit_matrix` after that edge, and not before it. A synchronous active-high `rst` clears every bit to zero.
- R2: Slots 0–3 are loads and slots 4–7 are stores. Bit `i*8+j` of `hit_matrix` is the entry for the pair (slot i, slot j). The diagonal bits are always zero. Any entry whose row slot or column slot has its valid bit low is zero.
- R3: The matrix is symmetric: bit `i*8+j` always equals bit `j*8+i`.
- R4: The size code in `op_size[2k+1:2k]` gives the access length: 00 = 1 byte, 01 = 2, 10 = 4, 11 = 8. Byte lanes run from the address bits 3:0 upward.
- R5: Unless a row-crossing access is involved, a pair is flagged only if address bits 11:4 of the two operations are identical.
- R6: Unless a row-crossing access is involved, a pair is flagged only if the byte-lane masks of the two operations have at least one lane in common.
- R7: The tag is address bits 21:17 XOR address bits 16:12. Unless a row-crossing access is involved, a pair is flagged only if the two tags are equal. Two addresses that differ only in bits that cancel in this fold are flagged.
- R8: Two accesses at the same offset in buffers 1MiB apart are reported as independent.
- R9: Misaligned 2-, 4- and 8-byte accesses that stay inside one 16-byte row are matched exactly by their lane masks.
- R10: An access whose offset within its 16-byte row plus its length exceeds 16 is flagged against every other valid slot.
- R11: For addresses below 4MiB, any pair of valid operations whose byte ranges truly overlap is always flagged (no false negatives).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 8 | Per-slot valid bit; slots 0–3 are loads and 4–7 are stores |
| op_addr | input | 512 | Byte addresses; slot k uses bits `64k+63:64k` |
| op_size | input | 16 | Size codes; slot k uses bits `2k+1:2k` |
| hit_matrix | output | 64 | Registered pair matrix; bit `i*8+j` is the entry for row i, column j |

## Verification
The assertions check the structural rules on every cycle: the diagonal and invalid slots stay zero, the matrix stays symmetric, reset clears it, row-crossing accesses force their whole row, and unequal bands or tags block a hit. They also check that two valid slots with identical addresses are always flagged. The exact lane-mask arithmetic for misaligned accesses, the 1MiB aliasing case, the fold that makes distant addresses collide, and the absence of false negatives over many clustered address patterns can only be shown by the bench. The bench compares every matrix bit against a model built from the requirements, and compares each bit against true byte-range overlap.

// File: rtl/lsq_match_pkg.sv
package lsq_match_pkg;
  localparam int OFF_W   = 4;
  localparam int LANES   = 1 << OFF_W;
  localparam int BAND_HI = 11;
  localparam int BAND_W  = BAND_HI - OFF_W + 1;
  localparam int TAG_W   = 5;
  localparam int TAG_LO  = BAND_HI + 1;
  localparam int FOLD_HI = TAG_LO + 2 * TAG_W - 1;
  localparam int LEN_W   = OFF_W + 1;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_DWORD = 2'b11
  } acc_size_e;

  typedef struct packed {
    logic              live;
    logic              spill;
    logic [BAND_W-1:0] band;
    logic [TAG_W-1:0]  tag;
    logic [LANES-1:0]  lanes;
  } op_key_t;
endpackage

// File: rtl/op_keygen.sv
module op_keygen
  import lsq_match_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output op_key_t           key
);
  localparam int RUN_W = 2 * LANES;

  logic [OFF_W-1:0] off;
  logic [LEN_W-1:0] nbytes;
  logic [LEN_W:0]   span;
  logic [RUN_W-1:0] run;
  logic             unused_hi;

  assign unused_hi = ^addr[ADDR_W-1:FOLD_HI+1];

  always_comb begin
    off    = addr[OFF_W-1:0];
    nbytes = LEN_W'(1) << size;
    span   = {2'b00, off} + {1'b0, nbytes};
    run    = ((RUN_W'(1) << nbytes) - RUN_W'(1)) << off;
    key.live  = valid;
    key.spill = span > (LEN_W + 1)'(LANES);
    key.band  = addr[BAND_HI:OFF_W];
    key.tag   = addr[TAG_LO+TAG_W-1:TAG_LO] ^ addr[FOLD_HI:TAG_LO+TAG_W];
    key.lanes = run[LANES-1:0];
  end
endmodule

// File: rtl/pair_judge.sv
module pair_judge
  import lsq_match_pkg::*;
(
  input  op_key_t key_a,
  input  op_key_t key_b,
  output logic    hit
);
  logic near;
  logic overlap;

  always_comb begin
    near    = (key_a.band == key_b.band) && (key_a.tag == key_b.tag);
    overlap = |(key_a.lanes & key_b.lanes);
    hit     = key_a.live && key_b.live &&
              (key_a.spill || key_b.spill || (near && overlap));
  end
endmodule

// File: rtl/hit_matrix_reg.sv
module hit_matrix_reg #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) $past(rst) |-> (q == '0)); // R1
endmodule

// File: rtl/lsq_overlap_matrix.sv
module lsq_overlap_matrix
  import lsq_match_pkg::*;
#(
  parameter int N_LD   = 4,
  parameter int N_ST   = 4,
  parameter int ADDR_W = 64
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [N_LD+N_ST-1:0]             op_valid,
  input  logic [(N_LD+N_ST)*ADDR_W-1:0]    op_addr,
  input  logic [(N_LD+N_ST)*2-1:0]         op_size,
  output logic [(N_LD+N_ST)*(N_LD+N_ST)-1:0] hit_matrix
);
  localparam int N_OPS = N_LD + N_ST;
  localparam int M_W   = N_OPS * N_OPS;

  op_key_t          key [N_OPS];
  logic [M_W-1:0]   hit_next;

  for (genvar k = 0; k < N_OPS; k++) begin : g_key
    op_keygen #(.ADDR_W(ADDR_W)) u_key (
      .valid (op_valid[k]),
      .addr  (op_addr[k*ADDR_W +: ADDR_W]),
      .size  (op_size[k*2 +: 2]),
      .key   (key[k])
    );
  end

  for (genvar i = 0; i < N_OPS; i++) begin : g_row
    for (genvar j = 0; j < N_OPS; j++) begin : g_col
      if (i == j) begin : g_diag
        assign hit_next[i*N_OPS+j] = 1'b0;
      end else begin : g_pair
        pair_judge u_pair (
          .key_a (key[i]),
          .key_b (key[j]),
          .hit   (hit_next[i*N_OPS+j])
        );

        AST_SYMMETRIC: assert property (@(posedge clk) disable iff (rst)
          hit_matrix[i*N_OPS+j] == hit_matrix[j*N_OPS+i]); // R3
        AST_SPILL_ROW: assert property (@(posedge clk) disable iff (rst)
          (key[i].live && key[j].live && key[i].spill) |=> hit_matrix[i*N_OPS+j]); // R10
        AST_BAND_GATE: assert property (@(posedge clk) disable iff (rst)
          (!key[i].spill && !key[j].spill && key[i].band != key[j].band)
          |=> !hit_matrix[i*N_OPS+j]); // R5
        AST_TAG_GATE: assert property (@(posedge clk) disable iff (rst)
          (!key[i].spill && !key[j].spill && key[i].tag != key[j].tag)
          |=> !hit_matrix[i*N_OPS+j]); // R7
        AST_SAME_ADDR: assert property (@(posedge clk) disable iff (rst)
          (op_valid[i] && op_valid[j] &&
           op_addr[i*ADDR_W +: ADDR_W] == op_addr[j*ADDR_W +: ADDR_W])
          |=> hit_matrix[i*N_OPS+j]); // R11
      end
    end

    AST_DIAG_ZERO: assert property (@(posedge clk) disable iff (rst)
      !hit_matrix[i*N_OPS+i]); // R2
    AST_DEAD_ROW: assert property (@(posedge clk) disable iff (rst)
      !op_valid[i] |=> (hit_matrix[i*N_OPS +: N_OPS] == '0)); // R2
  end

  hit_matrix_reg #(.W(M_W)) u_mreg (
    .clk (clk),
    .rst (rst),
    .d   (hit_next),
    .q   (hit_matrix)
  );
endmodule

// File: tb/tb_lsq_overlap_matrix.sv
module tb_lsq_overlap_matrix;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  op_valid;
  logic [511:0]  op_addr;
  logic [15:0]   op_size;
  logic [63:0]   hit_matrix;

  logic          v_a [N];
  logic [63:0]   a_a [N];
  logic [1:0]    s_a [N];

  int tests = 0;
  int fails = 0;
  int false_pos = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int k = 0; k < N; k++) begin
      op_valid[k]          = v_a[k];
      op_addr[k*64 +: 64]  = a_a[k];
      op_size[k*2 +: 2]    = s_a[k];
    end
  end

  lsq_overlap_matrix dut (
    .clk(clk), .rst(rst), .op_valid(op_valid),
    .op_addr(op_addr), .op_size(op_size), .hit_matrix(hit_matrix)
  );

  function automatic int nbytes(int k);
    return 1 << s_a[k];
  endfunction

  // Requirement model: band / lane / folded tag / row-crossing rules.
  function automatic logic model_hit(int i, int j);
    int oi, oj;
    logic [31:0] mi, mj;
    logic ci, cj, band_eq, tag_eq;
    if (i == j || !v_a[i] || !v_a[j]) return 1'b0;
    oi = int'(a_a[i][3:0]);
    oj = int'(a_a[j][3:0]);
    ci = (oi + nbytes(i)) > 16;
    cj = (oj + nbytes(j)) > 16;
    if (ci || cj) return 1'b1;
    mi = ((32'd1 << nbytes(i)) - 1) << oi;
    mj = ((32'd1 << nbytes(j)) - 1) << oj;
    band_eq = a_a[i][11:4] == a_a[j][11:4];
    tag_eq  = (a_a[i][21:17] ^ a_a[i][16:12]) == (a_a[j][21:17] ^ a_a[j][16:12]);
    return band_eq && tag_eq && ((mi & mj & 32'hFFFF) != 0);
  endfunction

  function automatic logic true_ovl(int i, int j);
    if (i == j || !v_a[i] || !v_a[j]) return 1'b0;
    return (a_a[i] < a_a[j] + 64'(nbytes(j))) && (a_a[j] < a_a[i] + 64'(nbytes(i)));
  endfunction

  function automatic logic [63:0] model_matrix();
    logic [63:0] m;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        m[i*N+j] = model_hit(i, j);
    return m;
  endfunction

  task automatic check_eq(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: hit_matrix=%016h expected %016h", req, act, exp);
    end
  endtask

  task automatic clear_ops();
    for (int k = 0; k < N; k++) begin
      v_a[k] = 1'b0; a_a[k] = 64'h0; s_a[k] = 2'b00;
    end
  endtask

  task automatic put(int k, logic [63:0] addr, logic [1:0] sz);
    v_a[k] = 1'b1; a_a[k] = addr; s_a[k] = sz;
  endtask

  // Inputs change at a falling edge; result sampled at the next falling edge.
  task automatic settle();
    @(negedge clk);
  endtask

  function automatic logic [63:0] pair_bits(int i, int j);
    logic [63:0] m = '0;
    m[i*N+j] = 1'b1;
    m[j*N+i] = 1'b1;
    return m;
  endfunction

  task automatic t_reset();
    clear_ops();
    put(0, 64'h1000, 2'b11); put(4, 64'h1000, 2'b11);
    rst = 1'b1;
    settle();
    check_eq("R1 reset clears", hit_matrix, 64'h0);
    rst = 1'b0;
    settle();
    check_eq("R1 R2 first pair after reset", hit_matrix, pair_bits(0, 4));
  endtask

  task automatic t_timing();
    clear_ops();
    settle();
    check_eq("R2 nothing valid", hit_matrix, 64'h0);
    put(1, 64'h2230, 2'b10); put(6, 64'h2232, 2'b01);
    #1;
    check_eq("R1 not before edge", hit_matrix, 64'h0);
    settle();
    check_eq("R1 R11 after edge", hit_matrix, pair_bits(1, 6));
  endtask

  task automatic t_band();
    clear_ops();
    put(0, 64'h1000, 2'b10); put(5, 64'h1010, 2'b10);
    settle();
    check_eq("R5 band differs", hit_matrix, 64'h0);
  endtask

  task automatic t_lanes();
    clear_ops();
    put(2, 64'h2000, 2'b10); put(7, 64'h2004, 2'b10);
    settle();
    check_eq("R6 R4 disjoint lanes", hit_matrix, 64'h0);
    put(2, 64'h2002, 2'b01); put(7, 64'h2003, 2'b00);
    settle();
    check_eq("R6 R4 shared lane", hit_matrix, pair_bits(2, 7));
  endtask

  task automatic t_fold();
    clear_ops();
    put(0, 64'h0000_0040, 2'b11); put(4, 64'h0010_0040, 2'b11);
    settle();
    check_eq("R8 1MiB apart independent", hit_matrix, 64'h0);
    put(0, 64'h0002_0040, 2'b11); put(4, 64'h0000_1040, 2'b11);
    settle();
    check_eq("R7 fold collision flagged", hit_matrix, pair_bits(0, 4));
  endtask

  task automatic t_misaligned();
    clear_ops();
    put(1, 64'h3003, 2'b10); put(5, 64'h3006, 2'b00);
    put(3, 64'h3001, 2'b01); put(6, 64'h3008, 2'b11);
    settle();
    check_eq("R9 misaligned lanes", hit_matrix, model_matrix());
    check_eq("R9 misaligned expected pairs", hit_matrix, pair_bits(1, 5));
  endtask

  task automatic t_spill();
    clear_ops();
    put(2, 64'h400E, 2'b10);
    put(0, 64'h9_0000, 2'b00); put(5, 64'h7_7770, 2'b11); put(7, 64'h40_0000, 2'b01);
    settle();
    check_eq("R10 R2 row crossing", hit_matrix,
             pair_bits(2, 0) | pair_bits(2, 5) | pair_bits(2, 7));
  endtask

  task automatic t_sweep();
    for (int it = 0; it < 400; it++) begin
      logic [63:0] base;
      logic [63:0] m;
      base = {42'h0, 22'($urandom) & 22'h3F_FF00};
      for (int k = 0; k < N; k++) begin
        v_a[k] = ($urandom % 5) != 0;
        s_a[k] = 2'($urandom);
        case ($urandom % 4)
          0: a_a[k] = base + 64'($urandom % 24);
          1: a_a[k] = base + 64'($urandom % 48);
          2: a_a[k] = (base ^ 64'h10_0000) + 64'($urandom % 16);
          default: a_a[k] = {42'h0, 22'($urandom)};
        endcase
        if (a_a[k] + 64'(nbytes(k)) > 64'h40_0000) a_a[k] = 64'h40_0000 - 64'(nbytes(k));
      end
      settle();
      m = model_matrix();
      check_eq("R3 R11 sweep vs model", hit_matrix, m);
      tests++;
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin
          if (true_ovl(i, j) && !hit_matrix[i*N+j]) begin
            fails++;
            $display("FAIL R11 false negative slots %0d,%0d: act=0 exp=1", i, j);
          end
          if (!true_ovl(i, j) && hit_matrix[i*N+j]) false_pos++;
          if (hit_matrix[i*N+j] !== hit_matrix[j*N+i]) begin
            fails++;
            $display("FAIL R3 asymmetric %0d,%0d: act=%b exp=%b", i, j,
                     hit_matrix[i*N+j], hit_matrix[j*N+i]);
          end
        end
    end
    $display("[TB] sweep false positives (allowed): %0d", false_pos);
  endtask

  initial begin
    clear_ops();
    repeat (2) @(negedge clk);
    t_reset();
    t_timing();
    t_band();
    t_lanes();
    t_fold();
    t_misaligned();
    t_spill();
    t_sweep();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    tests++;
    fails++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule